// File: doc/BRIEF.md
# Two-Beat Split-Port Synchronous Memory

This block models a static memory with a separate read port and write port, both active in every clock cycle. It runs from a single fast clock at twice the command rate. Alternating edges of that clock act as the two command-clock edges: the "K" edge and the "K#" edge half a cycle later. The output `k_slot` is high during each half-cycle that ends in a K edge, so a driver knows which half it is filling.

One shared address bus carries the read address in the K half and the write address in the K# half. Every access moves two data words: beat 0 at the base word and beat 1 at the word that follows it. Write data for beat 0 arrives half a cycle before its address, so a write is assembled in an internal buffer. The buffer keeps the most recent write until the next write arrives, and only then commits it to the array. Reads compare against this buffer, so they always see earlier writes. Read data comes back as a two-beat burst after a fixed latency, together with a valid strobe.

The output can be timed from the command clock (single-clock mode). It can also be timed from a separate output clock that lags the command clock by a fixed number of half-cycles.

Top module: `qburst2_sram`

## Requirements
- R1: `k_slot` alternates every half-cycle and is high right after reset. The K edge captures `rd_n`, `wr_n`, the read address, beat-0 `wdata` and beat-0 `bwe_n`. The following K# edge captures the write address, beat-1 `wdata` and beat-1 `bwe_n`. `rd_n` and `wr_n` are active low.
- R2: Every access is a two-word burst. Beat 0 uses word address {addr,0} and beat 1 uses word address {addr,1}. Each beat has its own data and its own byte mask.
- R3: Bit i of `bwe_n` low writes byte i (bits 8i+7..8i) of that beat. Bit i high leaves that byte unchanged, so an all-ones mask changes nothing.
- R4: When `wr_n` is high at a K edge, no data from that cycle reaches the array.
- R5: With `c_tied_hi` = 1, beat 0 of a read issued at K edge E appears on `q` with `q_valid` high just after edge E+3 (1.5 command cycles later). Beat 1 follows just after edge E+4.
- R6: With `c_tied_hi` = 0, the same stream appears C_LAG half-cycles later than in R5. `c_tied_hi` changes only while reset is held.
- R7: In any half-cycle that carries no read beat, `q_valid` is low and `q` is zero.
- R8: A read and a write may be issued in the same cycle without disturbing each other. That read returns the contents as they were before the write issued at the same K edge.
- R9: A read issued in any later cycle returns every byte written by earlier writes, including a write still held in the buffer, merged byte by byte under its mask.
- R10: While `rst_n` is low, `q_valid` is low and `q` is zero, and a write still held in the buffer is discarded. Words already committed to the array are kept.
- R11: Reads issued on consecutive K edges give an unbroken stream of beats, with `q_valid` high in every half-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; alternate edges are K and K# |
| rst_n | input | 1 | Synchronous active-low reset |
| k_slot | output | 1 | High in the half-cycle that ends in a K edge |
| c_tied_hi | input | 1 | 1: output timed from command clock; 0: from lagging output clock |
| rd_n | input | 1 | Read request, active low, sampled at K |
| wr_n | input | 1 | Write request, active low, sampled at K |
| addr | input | ADDR_W | Read address in K half, write address in K# half |
| wdata | input | DATA_W | Beat-0 data in K half, beat-1 data in K# half |
| bwe_n | input | DATA_W/8 | Byte write mask, active low, per beat |
| q | output | DATA_W | Read beat data |
| q_valid | output | 1 | High while `q` carries a read beat |

## Verification
Stimulus is a constrained random mix of reads and writes over a few addresses, so the buffer is hit often, plus directed cases. The reference is a byte-masked model array. If the buffer merge or the commit is wrong, the port shows it 3 to 5 half-cycles after the next read of the affected address: a single byte differs on `q`. If the output pipeline is wrong, beats arrive one half-cycle early or late, or swapped, and the very first read reveals it. If the phase is wrong, beat-1 data lands in beat 0 from the first write onward.

// File: rtl/qburst2_sram.sv
module qburst2_sram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int C_LAG  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic                     k_slot,
  input  logic                     c_tied_hi,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W/BYTE_W-1:0] bwe_n,
  output logic [DATA_W-1:0]        q,
  output logic                     q_valid
);
  localparam int NB    = DATA_W / BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
                                               input logic [DATA_W-1:0] new_w,
                                               input logic [NB-1:0]     en);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < NB; i++)
      r[i*BYTE_W +: BYTE_W] = en[i] ? new_w[i*BYTE_W +: BYTE_W] : old_w[i*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic              ph;
  logic              rcmd, wcmd;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] wd0;
  logic [NB-1:0]     wm0;

  logic              bv;
  logic [ADDR_W-1:0] ba;
  logic [DATA_W-1:0] bd0, bd1;
  logic [NB-1:0]     bm0, bm1;

  logic [DATA_W-1:0] mem0 [DEPTH];
  logic [DATA_W-1:0] mem1 [DEPTH];

  logic [DATA_W-1:0] rd0, rd1, hold, sq;
  logic              rv, hv, sv;
  logic              hit;

  assign k_slot = ~ph;
  assign hit    = bv && (ba == raddr);

  always_ff @(posedge clk) begin
    if (rst_n && ph && wcmd && bv) begin
      mem0[ba] <= merge(mem0[ba], bd0, bm0);
      mem1[ba] <= merge(mem1[ba], bd1, bm1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= 1'b0;
      rcmd  <= 1'b0;
      wcmd  <= 1'b0;
      raddr <= '0;
      wd0   <= '0;
      wm0   <= '0;
      bv    <= 1'b0;
      ba    <= '0;
      bd0   <= '0;
      bd1   <= '0;
      bm0   <= '0;
      bm1   <= '0;
      rd0   <= '0;
      rd1   <= '0;
      rv    <= 1'b0;
      hold  <= '0;
      hv    <= 1'b0;
      sq    <= '0;
      sv    <= 1'b0;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        rcmd  <= ~rd_n;
        wcmd  <= ~wr_n;
        raddr <= addr;
        wd0   <= wdata;
        wm0   <= ~bwe_n;
        sq    <= hold;
        sv    <= hv;
      end else begin
        sq   <= rv ? rd0 : '0;
        sv   <= rv;
        hold <= rv ? rd1 : '0;
        hv   <= rv;
        rv   <= rcmd;
        if (rcmd) begin
          rd0 <= merge(mem0[raddr], bd0, hit ? bm0 : '0);
          rd1 <= merge(mem1[raddr], bd1, hit ? bm1 : '0);
        end
        if (wcmd) begin
          bv  <= 1'b1;
          ba  <= addr;
          bd0 <= wd0;
          bd1 <= wdata;
          bm0 <= wm0;
          bm1 <= ~bwe_n;
        end
      end
    end
  end

  generate
    if (C_LAG > 0) begin : g_lag
      logic [DATA_W-1:0] dq [C_LAG];
      logic [C_LAG-1:0]  dv;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          dv <= '0;
          for (int i = 0; i < C_LAG; i++) dq[i] <= '0;
        end else begin
          dq[0] <= sq;
          dv[0] <= sv;
          for (int i = 1; i < C_LAG; i++) begin
            dq[i] <= dq[i-1];
            dv[i] <= dv[i-1];
          end
        end
      end
      assign q       = c_tied_hi ? sq : dq[C_LAG-1];
      assign q_valid = c_tied_hi ? sv : dv[C_LAG-1];
    end else begin : g_nolag
      assign q       = sq;
      assign q_valid = sv;
    end
  endgenerate
endmodule

// File: rtl/qburst2_sram_chk.sv
module qburst2_sram_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              k_slot,
  input logic              c_tied_hi,
  input logic              rd_n,
  input logic [DATA_W-1:0] q,
  input logic              q_valid
);
  AST_PHASE_TO_KN: assert property (@(posedge clk) disable iff (!rst_n) k_slot |=> !k_slot); // R1
  AST_PHASE_TO_K: assert property (@(posedge clk) disable iff (!rst_n) !k_slot |=> k_slot); // R1
  AST_BURST_PAIR: assert property (@(posedge clk) disable iff (!rst_n) $rose(q_valid) |=> q_valid); // R2
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (k_slot && !rd_n && c_tied_hi) |=> ##3 q_valid); // R5
  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && c_tied_hi) |-> ($past(k_slot && !rd_n, 4) || $past(k_slot && !rd_n, 5))); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !q_valid |-> (q == '0)); // R7
endmodule

bind qburst2_sram qburst2_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .k_slot(k_slot), .c_tied_hi(c_tied_hi),
  .rd_n(rd_n), .q(q), .q_valid(q_valid)
);

// File: tb/sim_qburst2_sram.sv
module sim_qburst2_sram;
  localparam int AW = 4, DW = 32, NB = 4, LAG = 1;

  logic clk = 1'b0, rst_n = 1'b0, c_tied_hi = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] bwe_n = '1;
  logic          k_slot;
  logic [DW-1:0] q;
  logic          q_valid;

  always #5 clk = ~clk;

  qburst2_sram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(8), .C_LAG(LAG)) u0 (
    .clk(clk), .rst_n(rst_n), .k_slot(k_slot), .c_tied_hi(c_tied_hi),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata), .bwe_n(bwe_n),
    .q(q), .q_valid(q_valid));

  logic [DW-1:0] ref0 [16];
  logic [DW-1:0] ref1 [16];
  logic [DW-1:0] ed [16];
  logic          ev [16];
  string         et [16];
  int n = 0, lag = 0, checks = 0, fails = 0;
  bit            lw_v = 1'b0;
  logic [AW-1:0] lw_a;
  logic [DW-1:0] pre0, pre1;

  function automatic void chk(bit ok, string tag, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endfunction

  function automatic void clr();
    for (int i = 0; i < 16; i++) begin
      ev[i] = 1'b0; ed[i] = '0; et[i] = "R7";
    end
  endfunction

  function automatic logic [DW-1:0] mrg(logic [DW-1:0] old_w, logic [DW-1:0] new_w, logic [NB-1:0] m_n);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < NB; i++)
      if (!m_n[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction

  task automatic cmp();
    int s = n % 16;
    chk(q_valid === ev[s] && q === ed[s], et[s], {q_valid, q}, {ev[s], ed[s]});
    ev[s] = 1'b0; ed[s] = '0; et[s] = "R7";
  endtask

  task automatic step();
    @(negedge clk);
    n++;
    cmp();
  endtask

  task automatic cyc(input bit rdo, input logic [AW-1:0] ra, input bit wro, input logic [AW-1:0] wa,
                     input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                     input logic [NB-1:0] m0, input logic [NB-1:0] m1, input string tg);
    int s0, s1;
    chk(k_slot === 1'b1, "R1", {32'd0, k_slot}, 33'd1);
    if (rdo) begin
      s0 = (n + 4 + lag) % 16;
      s1 = (n + 5 + lag) % 16;
      ed[s0] = ref0[ra]; ev[s0] = 1'b1; et[s0] = tg;
      ed[s1] = ref1[ra]; ev[s1] = 1'b1; et[s1] = tg;
    end
    if (wro) begin
      lw_v = 1'b1; lw_a = wa; pre0 = ref0[wa]; pre1 = ref1[wa];
      ref0[wa] = mrg(ref0[wa], d0, m0);
      ref1[wa] = mrg(ref1[wa], d1, m1);
    end
    rd_n = ~rdo; wr_n = ~wro; addr = ra; wdata = d0; bwe_n = m0;
    step();
    addr = wa; wdata = d1; bwe_n = m1; rd_n = 1'b1; wr_n = 1'b1;
    step();
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, $urandom, $urandom, NB'($urandom), NB'($urandom), "R7");
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(q_valid === 1'b0 && q === '0, "R10", {q_valid, q}, '0);
    c_tied_hi = mode;
    lag = mode ? 0 : LAG;
    clr();
    if (lw_v) begin ref0[lw_a] = pre0; ref1[lw_a] = pre1; end
    lw_v = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic rand_run(input int k, input string tg);
    for (int i = 0; i < k; i++)
      cyc(($urandom % 4) != 0, AW'($urandom % 4), $urandom % 2, AW'($urandom % 4),
          $urandom, $urandom, NB'($urandom), NB'($urandom), tg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd24601);
    clr();
    do_reset(1'b1);

    // R2: fill every burst pair with full-mask writes
    for (int a = 0; a < 16; a++) cyc(0, 0, 1, AW'(a), $urandom, $urandom, '0, '0, "R2");
    // R11: back-to-back reads, unbroken stream
    for (int a = 0; a < 16; a++) cyc(1, AW'(a), 0, 0, '0, '0, '1, '1, "R2 R11");
    idle(2);

    // R3: partial byte masks per beat, R9: read while held in buffer
    cyc(0, 0, 1, 3, 32'hAABBCCDD, 32'h11223344, 4'b1010, 4'b0101, "R3");
    cyc(1, 3, 0, 0, '0, '0, '1, '1, "R9");
    // R8: same-cycle read and write to one address returns prior contents
    cyc(1, 3, 1, 3, 32'h55667788, 32'h99AABBCC, 4'b0000, 4'b1100, "R8");
    cyc(1, 3, 0, 0, '0, '0, '1, '1, "R9");
    // R3: all bytes masked
    cyc(0, 0, 1, 7, $urandom, $urandom, 4'hF, 4'hF, "R3");
    cyc(0, 0, 1, 6, $urandom, $urandom, '0, '0, "R3");
    cyc(1, 7, 0, 0, '0, '0, '1, '1, "R3");
    // R4: wr_n high with data and open masks
    cyc(0, 0, 0, 8, $urandom, $urandom, '0, '0, "R4");
    cyc(0, 0, 1, 2, $urandom, $urandom, '0, '1, "R4");
    cyc(1, 8, 0, 0, '0, '0, '1, '1, "R4");
    // back-to-back writes to one address
    cyc(0, 0, 1, 9, $urandom, $urandom, 4'b0011, 4'b1001, "R9");
    cyc(1, 9, 1, 9, $urandom, $urandom, 4'b0110, 4'b0000, "R8");
    cyc(1, 9, 0, 0, '0, '0, '1, '1, "R9");
    idle(3);

    rand_run(300, "R5");

    // R10: held write discarded by reset; then lagged output clock
    cyc(0, 0, 1, 5, $urandom, $urandom, '0, '0, "R10");
    idle(1);
    do_reset(1'b0);
    cyc(1, 5, 0, 0, '0, '0, '1, '1, "R10");
    cyc(1, 6, 0, 0, '0, '0, '1, '1, "R6");
    rand_run(200, "R6");
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule